// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a free-running calendar driven by a subsecond tick. A binary subsecond counter counts tick pulses. When it wraps, it advances a calendar held entirely in BCD: seconds, minutes, hours, weekday, date, month and year. The hour field runs either from 00 to 23, or from 01 to 12 with a PM flag. Month lengths come from a table. February has 29 days when the two-digit BCD year is a multiple of four.

Software uses a small register bus with one write strobe and a combinational read port. Through it, software loads and reads the packed time word and the packed date word, and reads the subsecond count. It also programs two alarms. Each alarm compares the full calendar, and each field of an alarm can be masked out. When an alarm matches, it latches a sticky flag that drives an interrupt line. Software clears the flag by writing a one to it.

Top module: `bcd_cal_rtc`

## Requirements
- R1: After reset the time word (address 0) reads 0, which is 00:00:00 in 24-hour mode. The date word (address 1) reads 0x01010100, which is weekday 1, date 01, month 01, year 00. The subsecond count (address 2) reads 0, and the flag register (address 7) reads 0.
- R2: A tick counts only while `runEn` is high. Each such tick adds one to the binary subsecond count. The count wraps to 0 after SUB_LAST and advances the calendar by one second at that wrap. Ticks that arrive while `runEn` is low change nothing.
- R3: Seconds roll over from 59 to 00 and carry into minutes. Minutes roll over from 59 to 00 and carry into hours. All fields count in BCD.
- R4: The time word layout is: seconds [6:0], minutes [14:8], hours [21:16], PM flag [22], 12-hour mode [24]. In 24-hour mode the hours go from 23 to 00, and that step advances the date.
- R5: In 12-hour mode the hours go from 11 to 12 and the PM flag toggles, and from 12 to 01 the PM flag does not change. The step from 11 PM to 12 AM advances the date.
- R6: The date word layout is: year [7:0], month [12:8], date [21:16], weekday [26:24]. On every date advance the weekday goes from 7 to 1 and otherwise counts up by one.
- R7: A date past the last day of its month becomes 01 and the month advances. Months 04, 06, 09 and 11 end on 30. Month 02 ends on 29 when the BCD year is a multiple of four and on 28 otherwise. The other months end on 31. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: A write to the time word or the date word replaces all of that word's fields in one cycle and clears the subsecond count. In that cycle the write wins over a tick.
- R9: Each alarm has two registers. Alarm k's time register is at address 3+2k and uses the time layout plus masks: seconds [28], minutes [29], hour with PM [30]. Its date register is at address 4+2k and uses the date layout plus masks: year [28], month [29], date [30], weekday [31]. At a second wrap, flag k sets when every unmasked field equals the new calendar value. A masked field always counts as matching.
- R10: Flag k is bit k of address 7. It stays set until a write to address 7 with bit k equal to 1. A write with bit k equal to 0 leaves it unchanged. When a set and a clear of the same flag fall in the same cycle, the set wins.
- R11: `alarmIrq[k]` follows flag k. The two alarms match and latch independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Subsecond tick pulse, one per cycle when high |
| runEn | input | 1 | Calendar run enable |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from `busAddr` |
| alarmIrq | output | 2 | Per-alarm interrupt, one per sticky flag |

## Verification
The set path of an alarm flag and the software write that clears the same flag can land on the same clock edge. The bench provokes this by counting tick cycles up to the exact wrap that reaches the alarm time. On that cycle it issues the clearing write to the flag register, with the tick still asserted. The flag must still read one afterwards while the time shows the new second, so a design that lets the clear win is caught.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_ALARM = 2;

  localparam logic [2:0] ADDR_TIME = 3'd0;
  localparam logic [2:0] ADDR_DATE = 3'd1;
  localparam logic [2:0] ADDR_SUB  = 3'd2;
  localparam logic [2:0] ADDR_FLAG = 3'd7;
  localparam int         ADDR_ALARM_BASE = 3;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic       pm;
    logic       mode12;
    logic [2:0] wday;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } calTime_t;

  // mask bits: 0 sec, 1 min, 2 hour+pm, 3 year, 4 month, 5 date, 6 weekday
  typedef struct packed {
    calTime_t   t;
    logic [6:0] mask;
  } alarm_t;

  typedef struct packed {
    logic wrTime;
    logic wrDate;
    logic step;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc8(logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcdToBin(logic [7:0] v);
    logic [6:0] r;
    r = ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
    return r;
  endfunction

  function automatic logic [5:0] monthLast(logic [4:0] month, logic [7:0] year);
    logic [6:0] yb;
    logic [5:0] r;
    yb = bcdToBin(year);
    case (month)
      5'h02:                      r = (yb[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] packTime(calTime_t t);
    return {7'b0, t.mode12, 1'b0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
  endfunction

  function automatic logic [31:0] packDate(calTime_t t);
    return {5'b0, t.wday, 2'b0, t.date, 3'b0, t.month, t.year};
  endfunction

  function automatic logic alarmHit(alarm_t a, calTime_t t);
    logic hit;
    hit = (a.mask[0] || (a.t.sec == t.sec))
       && (a.mask[1] || (a.t.min == t.min))
       && (a.mask[2] || ((a.t.hour == t.hour) && (a.t.pm == t.pm)))
       && (a.mask[3] || (a.t.year == t.year))
       && (a.mask[4] || (a.t.month == t.month))
       && (a.mask[5] || (a.t.date == t.date))
       && (a.mask[6] || (a.t.wday == t.wday));
    return hit;
  endfunction

endpackage

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int SUB_W    = 8,
  parameter int SUB_LAST = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strobe,
  input  logic [31:0]      wdata,
  output calTime_t         cur,
  output calTime_t         nxt,
  output logic [SUB_W-1:0] subsec,
  output logic             secWrap
);

  localparam logic [SUB_W-1:0] SUB_END = SUB_LAST[SUB_W-1:0];

  logic unusedBits;
  assign unusedBits = ^{wdata[31:27], wdata[23], wdata[15]};

  assign secWrap = strobe.step && (subsec == SUB_END);

  // one-second advance of the whole calendar
  always_comb begin
    logic [7:0] inc8;
    logic       minCarry;
    logic       hourCarry;
    logic       dayCarry;
    nxt       = cur;
    minCarry  = 1'b0;
    hourCarry = 1'b0;
    dayCarry  = 1'b0;
    inc8      = 8'h00;

    if (cur.sec == 7'h59) begin
      nxt.sec  = 7'h00;
      minCarry = 1'b1;
    end else begin
      inc8    = bcdInc8({1'b0, cur.sec});
      nxt.sec = inc8[6:0];
    end

    if (minCarry) begin
      if (cur.min == 7'h59) begin
        nxt.min   = 7'h00;
        hourCarry = 1'b1;
      end else begin
        inc8    = bcdInc8({1'b0, cur.min});
        nxt.min = inc8[6:0];
      end
    end

    if (hourCarry) begin
      if (cur.mode12) begin
        if (cur.hour == 6'h12) begin
          nxt.hour = 6'h01;
        end else begin
          inc8     = bcdInc8({2'b0, cur.hour});
          nxt.hour = inc8[5:0];
          if (cur.hour == 6'h11) begin
            nxt.pm   = ~cur.pm;
            dayCarry = cur.pm;
          end
        end
      end else begin
        if (cur.hour == 6'h23) begin
          nxt.hour = 6'h00;
          dayCarry = 1'b1;
        end else begin
          inc8     = bcdInc8({2'b0, cur.hour});
          nxt.hour = inc8[5:0];
        end
      end
    end

    if (dayCarry) begin
      nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
      if (cur.date == monthLast(cur.month, cur.year)) begin
        nxt.date = 6'h01;
        if (cur.month == 5'h12) begin
          nxt.month = 5'h01;
          nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcdInc8(cur.year);
        end else begin
          inc8      = bcdInc8({3'b0, cur.month});
          nxt.month = inc8[4:0];
        end
      end else begin
        inc8     = bcdInc8({2'b0, cur.date});
        nxt.date = inc8[5:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur        <= '0;
      cur.wday   <= 3'd1;
      cur.date   <= 6'h01;
      cur.month  <= 5'h01;
      subsec     <= '0;
    end else if (strobe.wrTime) begin
      cur.sec    <= wdata[6:0];
      cur.min    <= wdata[14:8];
      cur.hour   <= wdata[21:16];
      cur.pm     <= wdata[22];
      cur.mode12 <= wdata[24];
      subsec     <= '0;
    end else if (strobe.wrDate) begin
      cur.year   <= wdata[7:0];
      cur.month  <= wdata[12:8];
      cur.date   <= wdata[21:16];
      cur.wday   <= wdata[26:24];
      subsec     <= '0;
    end else if (strobe.step) begin
      if (secWrap) begin
        subsec <= '0;
        cur    <= nxt;
      end else begin
        subsec <= subsec + 1'b1;
      end
    end
  end

  // R8: a load always restarts the subsecond count
  p_load_clears_sub_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrTime || strobe.wrDate) |=> (subsec == '0));

  // R2: without a step or a load nothing moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.wrTime && !strobe.wrDate) |=> ($stable(cur) && $stable(subsec)));

  // R2: a step inside a second leaves the calendar alone
  p_mid_second_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !secWrap) |=> $stable(cur));

  // R2: wrap returns the subsecond count to zero and changes the calendar
  p_wrap_restarts_r2: assert property (@(posedge clk) disable iff (!rstN)
    secWrap |=> ((subsec == '0) && (cur != $past(cur))));

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int SUB_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 runEn,
  input  logic                 busWe,
  input  logic [2:0]           busAddr,
  input  logic [31:0]          busWdata,
  input  calTime_t             cur,
  input  calTime_t             nxt,
  input  logic [SUB_W-1:0]     subsec,
  input  logic                 secWrap,
  output calStrobe_t           strobe,
  output logic [31:0]          busRdata,
  output logic [NUM_ALARM-1:0] alarmIrq
);

  logic unusedBits;
  assign unusedBits = ^{busWdata[27], busWdata[23], busWdata[15], nxt.mode12};

  logic [NUM_ALARM-1:0] flags;
  logic [NUM_ALARM-1:0] hit;
  logic [NUM_ALARM-1:0] clr;
  logic [31:0]          almTimeWord [NUM_ALARM];
  logic [31:0]          almDateWord [NUM_ALARM];

  assign strobe.wrTime = busWe && (busAddr == ADDR_TIME);
  assign strobe.wrDate = busWe && (busAddr == ADDR_DATE);
  assign strobe.step   = tickEn && runEn && !strobe.wrTime && !strobe.wrDate;

  assign clr = (busWe && (busAddr == ADDR_FLAG)) ? busWdata[NUM_ALARM-1:0] : '0;

  for (genvar k = 0; k < NUM_ALARM; k++) begin : g_alarm
    localparam logic [2:0] ADDR_AT = 3'(ADDR_ALARM_BASE + 2 * k);
    localparam logic [2:0] ADDR_AD = 3'(ADDR_ALARM_BASE + 2 * k + 1);

    alarm_t almReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        almReg <= '0;
      end else if (busWe && (busAddr == ADDR_AT)) begin
        almReg.t.sec     <= busWdata[6:0];
        almReg.t.min     <= busWdata[14:8];
        almReg.t.hour    <= busWdata[21:16];
        almReg.t.pm      <= busWdata[22];
        almReg.t.mode12  <= 1'b0;
        almReg.mask[2:0] <= busWdata[30:28];
      end else if (busWe && (busAddr == ADDR_AD)) begin
        almReg.t.year    <= busWdata[7:0];
        almReg.t.month   <= busWdata[12:8];
        almReg.t.date    <= busWdata[21:16];
        almReg.t.wday    <= busWdata[26:24];
        almReg.mask[6:3] <= busWdata[31:28];
      end
    end

    assign hit[k]         = secWrap && alarmHit(almReg, nxt);
    assign almTimeWord[k] = packTime(almReg.t) | {1'b0, almReg.mask[2:0], 28'b0};
    assign almDateWord[k] = packDate(almReg.t) | {almReg.mask[6:3], 28'b0};

    // R10: a flag holds unless its clear bit is written
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      (flags[k] && !clr[k]) |=> flags[k]);

    // R9: a flag can only rise on a second wrap
    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[k]) |-> $past(secWrap));

    // R10: set beats a same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      (hit[k] && clr[k]) |=> flags[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clr) | hit;
  end

  assign alarmIrq = flags;

  always_comb begin
    busRdata = 32'h0;
    case (busAddr)
      ADDR_TIME: busRdata = packTime(cur);
      ADDR_DATE: busRdata = packDate(cur);
      ADDR_SUB:  busRdata = {{(32 - SUB_W){1'b0}}, subsec};
      ADDR_FLAG: busRdata = {{(32 - NUM_ALARM){1'b0}}, flags};
      default: begin
        for (int k = 0; k < NUM_ALARM; k++) begin
          if (busAddr == 3'(ADDR_ALARM_BASE + 2 * k))     busRdata = almTimeWord[k];
          if (busAddr == 3'(ADDR_ALARM_BASE + 2 * k + 1)) busRdata = almDateWord[k];
        end
      end
    endcase
  end

endmodule

// File: rtl/bcd_cal_rtc.sv
module bcd_cal_rtc
  import cal_pkg::*;
#(
  parameter int SUB_W    = 8,
  parameter int SUB_LAST = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        runEn,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic [1:0]  alarmIrq
);

  calStrobe_t       strobe;
  calTime_t         cur;
  calTime_t         nxt;
  logic [SUB_W-1:0] subsec;
  logic             secWrap;

  cal_ctrl #(.SUB_W(SUB_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .runEn    (runEn),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cur      (cur),
    .nxt      (nxt),
    .subsec   (subsec),
    .secWrap  (secWrap),
    .strobe   (strobe),
    .busRdata (busRdata),
    .alarmIrq (alarmIrq)
  );

  cal_datapath #(.SUB_W(SUB_W), .SUB_LAST(SUB_LAST)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (busWdata),
    .cur     (cur),
    .nxt     (nxt),
    .subsec  (subsec),
    .secWrap (secWrap)
  );

endmodule

// File: tb/sim_bcd_cal_rtc.sv
`timescale 1ns/1ps
module sim_bcd_cal_rtc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        runEn = 1'b1;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [1:0]  alarmIrq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  bcd_cal_rtc #(.SUB_W(8), .SUB_LAST(3)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [2:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic dayRoll(string tag, logic [31:0] d, logic [31:0] t,
                         logic [31:0] expT, logic [31:0] expD);
    wr(3'd1, d);
    wr(3'd0, t);
    ticks(4);
    rdChk({tag, " time"}, 3'd0, expT);
    rdChk({tag, " date"}, 3'd1, expD);
  endtask

  task automatic testReset();
    rdChk("R1 time", 3'd0, 32'h0);
    rdChk("R1 date", 3'd1, 32'h0101_0100);
    rdChk("R1 subsec", 3'd2, 32'h0);
    rdChk("R1 flags", 3'd7, 32'h0);
  endtask

  task automatic testSubsec();
    ticks(2);
    rdChk("R2 subsec count", 3'd2, 32'd2);
    rdChk("R2 no second yet", 3'd0, 32'h0);
    runEn = 1'b0;
    ticks(5);
    rdChk("R2 runEn low holds", 3'd2, 32'd2);
    runEn = 1'b1;
    ticks(2);
    rdChk("R2 wrap subsec", 3'd2, 32'd0);
    rdChk("R2 wrap second", 3'd0, 32'h0000_0001);
  endtask

  task automatic testLoad();
    ticks(1);
    wr(3'd0, 32'h0000_5959);
    rdChk("R8 load clears subsec", 3'd2, 32'd0);
    ticks(4);
    rdChk("R3 sec/min carry", 3'd0, 32'h0001_0000);
    // write and tick in the same cycle
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    busAddr = 3'd0; busWdata = 32'h0000_0010; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    rdChk("R8 write beats tick subsec", 3'd2, 32'd0);
    rdChk("R8 write beats tick time", 3'd0, 32'h0000_0010);
  endtask

  task automatic testCalendar();
    dayRoll("R4 R6 R7 new year", 32'h0731_1299, 32'h0023_5959, 32'h0, 32'h0101_0100);
    wr(3'd0, 32'h0111_5959);
    ticks(4);
    rdChk("R5 11 to 12 PM", 3'd0, 32'h0152_0000);
    wr(3'd0, 32'h0152_5959);
    ticks(4);
    rdChk("R5 12 to 01 PM", 3'd0, 32'h0141_0000);
    dayRoll("R5 midnight 12h", 32'h0315_0624, 32'h0151_5959, 32'h0112_0000, 32'h0416_0624);
    dayRoll("R7 leap feb28", 32'h0228_0224, 32'h0023_5959, 32'h0, 32'h0329_0224);
    dayRoll("R7 leap feb29", 32'h0329_0224, 32'h0023_5959, 32'h0, 32'h0401_0324);
    dayRoll("R7 plain feb28", 32'h0528_0223, 32'h0023_5959, 32'h0, 32'h0601_0323);
    dayRoll("R7 bcd year 12 leap", 32'h0128_0212, 32'h0023_5959, 32'h0, 32'h0229_0212);
    dayRoll("R7 bcd year 10 plain", 32'h0128_0210, 32'h0023_5959, 32'h0, 32'h0201_0310);
    dayRoll("R7 april 30", 32'h0130_0423, 32'h0023_5959, 32'h0, 32'h0201_0523);
    dayRoll("R7 R6 jan 30", 32'h0630_0123, 32'h0023_5959, 32'h0, 32'h0731_0123);
  endtask

  task automatic testAlarms();
    rdChk("R9 no stray flag", 3'd7, 32'h0);
    wr(3'd1, 32'h0101_0100);
    wr(3'd3, 32'h0000_0005);
    wr(3'd4, 32'hF000_0000);
    rdChk("R9 alarm time readback", 3'd3, 32'h0000_0005);
    rdChk("R9 alarm date readback", 3'd4, 32'hF000_0000);
    wr(3'd0, 32'h0000_0003);
    ticks(4);
    rdChk("R9 no match yet", 3'd7, 32'h0);
    check("R11 irq idle", {30'b0, alarmIrq}, 32'h0);
    ticks(4);
    rdChk("R9 match sets flag", 3'd7, 32'h1);
    check("R11 irq follows flag", {30'b0, alarmIrq}, 32'h1);
    ticks(4);
    rdChk("R10 flag sticky", 3'd7, 32'h1);
    // alarm 1: seconds masked, minute 01
    wr(3'd5, 32'h1000_0100);
    wr(3'd6, 32'hF000_0000);
    wr(3'd0, 32'h0000_0059);
    ticks(4);
    rdChk("R11 second alarm independent", 3'd7, 32'h3);
    check("R11 irq both", {30'b0, alarmIrq}, 32'h3);
    wr(3'd7, 32'h0);
    rdChk("R10 write zero no effect", 3'd7, 32'h3);
    wr(3'd7, 32'h1);
    rdChk("R10 clear bit0 only", 3'd7, 32'h2);
    wr(3'd7, 32'h2);
    rdChk("R10 clear bit1", 3'd7, 32'h0);
  endtask

  task automatic testSetBeatsClear();
    wr(3'd3, 32'h0000_0007);
    wr(3'd0, 32'h0000_0006);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    busAddr = 3'd7; busWdata = 32'h1; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    rdChk("R10 collision time", 3'd0, 32'h0000_0007);
    rdChk("R10 set wins over clear", 3'd7, 32'h1);
    wr(3'd7, 32'h3);
    rdChk("R10 cleared after", 3'd7, 32'h0);
  endtask

  task automatic testDateField();
    wr(3'd4, 32'hB015_0000);
    wr(3'd1, 32'h0101_0100);
    wr(3'd0, 32'h0000_0006);
    ticks(4);
    rdChk("R9 unmasked date mismatch", 3'd7, 32'h0);
    wr(3'd1, 32'h0115_0100);
    wr(3'd0, 32'h0000_0006);
    ticks(4);
    rdChk("R9 unmasked date match", 3'd7, 32'h1);
    check("R11 irq date alarm", {30'b0, alarmIrq}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSubsec();
    testLoad();
    testCalendar();
    testAlarms();
    testSetBeatsClear();
    testDateField();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule